// File: doc/BRIEF.md
# DMA Channel Transfer Configuration with Legality Check

This block holds the transfer configuration of one DMA channel and decides whether an enable request may start a transfer. Software writes the setup through a simple word-wide register port: source and destination element widths, address stepping, burst lengths, master-port choice, security attributes, block byte count, start addresses and the destination address step. The rest of the channel receives the decoded fields directly.

An enable request is checked against the stored setup. If the setup is legal, the channel enables and emits a one-cycle start pulse. If any width code is reserved, the block count is not a whole number of source elements, or an address is misaligned, the enable is refused. In that case a sticky error is raised and nothing starts. The security attributes follow a channel-level secure flag: they are hidden from non-secure reads, writable only by secure writes, and wiped when the flag drops.

Top module: `dma_chan_cfg`

Register map (index on `wr_addr_i`/`rd_addr_i`):

| Index | Contents |
|---|---|
| 0 | Control. Write bit0=1 requests enable; write bit0=0 disables; write bit1=1 clears the error. Read: bit0 enable, bit1 error. |
| 1 | Setup word (layout below). |
| 2 | Block byte count. |
| 3 | Source start address. |
| 4 | Destination start address. |
| 5 | Destination address step. |
| 6, 7 | Not used; these read as 0. |

Setup word layout:

| Bits | Field |
|---|---|
| [1:0] | Source width code |
| [3:2] | Destination width code |
| 4 | Source increment |
| 5 | Destination increment |
| 6 | Source port |
| 7 | Destination port |
| 8 | Source secure |
| 9 | Destination secure |
| [15:10] | Source burst length minus one |
| [21:16] | Destination burst length minus one |

Width codes: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is reserved.

## Requirements
- R1: An enable request is refused, with `err_o` set, when the source or the destination width code is 3.
- R2: An enable request is refused, with `err_o` set, when the low bits of the block byte count are not a multiple of the source width (in bytes, 1 << code).
- R3: An enable request is refused, with `err_o` set, when the low three bits of the source address are not aligned to the source width.
- R4: An enable request is refused, with `err_o` set, when the destination address or the destination step is not aligned to the destination width.
- R5: A legal request made while disabled sets `enable_o` and raises `start_o` for exactly one cycle. Both outputs change on the edge that accepts the control write.
- R6: A refused request leaves `enable_o` at 0 and `start_o` low. `err_o` then stays 1, even across a later successful enable, until a control write with bit1=1 clears it.
- R7: Writes to the port bits (setup bits 6 and 7) take effect only while `enable_o` is 0. While it is 1 they are ignored.
- R8: Setup bits 8 and 9 change only on a write with `wr_secure_i`=1 while `chan_secure_i`=1. Any other write leaves them unchanged.
- R9: While `chan_secure_i` is 0, both security bits are cleared on the next clock edge and stay 0.
- R10: A read of the setup word returns 0 in bits 8 and 9 unless `rd_secure_i` and `chan_secure_i` are both 1.
- R11: After reset, every register and output is 0. The decoded widths therefore report 1 byte and the beat counts report 1.
- R12: `src_bytes_o`/`dst_bytes_o` equal 1 << width code, and `src_beats_o`/`dst_beats_o` equal the burst field plus one.
- R13: A control write with bit0=0 clears `enable_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_secure_i | input | 1 | Channel is configured secure |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register index |
| wr_data_i | input | DATA_W | Write data |
| wr_secure_i | input | 1 | Write is a secure access |
| rd_addr_i | input | 3 | Read register index |
| rd_secure_i | input | 1 | Read is a secure access |
| rd_data_o | output | DATA_W | Read data (combinational) |
| enable_o | output | 1 | Channel enabled |
| start_o | output | 1 | One-cycle transfer start |
| err_o | output | 1 | Sticky setup error |
| src_width_o | output | 2 | Source width code |
| dst_width_o | output | 2 | Destination width code |
| src_bytes_o | output | 4 | Source element size in bytes |
| dst_bytes_o | output | 4 | Destination element size in bytes |
| src_inc_o | output | 1 | Source address increments |
| dst_inc_o | output | 1 | Destination address increments |
| src_beats_o | output | 7 | Source beats per burst |
| dst_beats_o | output | 7 | Destination beats per burst |
| src_port_o | output | 1 | Source master port |
| dst_port_o | output | 1 | Destination master port |
| src_sec_o | output | 1 | Source access secure |
| dst_sec_o | output | 1 | Destination access secure |
| blk_bytes_o | output | CNT_W | Block byte count |
| src_addr_o | output | DATA_W | Source start address |
| dst_addr_o | output | DATA_W | Destination start address |
| dst_ofs_o | output | OFS_W | Destination address step |

## Verification
The bench drives every rejection path separately: a reserved code on each side, block counts that are odd or not a multiple of four, a misaligned source address, and a misaligned destination address or step. Each of these is paired with a nearly identical legal setup. A checker that tested the wrong width, or ignored one input, would therefore either start a bad transfer or refuse a good one.

Error stickiness is probed by enabling successfully while the flag is still set. A design that cleared the error on a new request would lose the flag at that point. Port locking is tested by writing the port bits while the channel is enabled. The security rules are exercised with non-secure writes, secure writes while the channel flag is low, masked non-secure reads, and dropping the channel flag. These catch a gate placed on the wrong access attribute, or a wipe that never happens.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int REG_AW = 3;
  localparam int BL_W   = 6;

  localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] REG_CFG   = 3'd1;
  localparam logic [REG_AW-1:0] REG_BLK   = 3'd2;
  localparam logic [REG_AW-1:0] REG_SADDR = 3'd3;
  localparam logic [REG_AW-1:0] REG_DADDR = 3'd4;
  localparam logic [REG_AW-1:0] REG_DOFS  = 3'd5;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_BAD  = 2'd3
  } width_e;

  typedef struct packed {
    logic [BL_W-1:0] dst_bl;
    logic [BL_W-1:0] src_bl;
    logic            dst_sec;
    logic            src_sec;
    logic            dst_port;
    logic            src_port;
    logic            dst_inc;
    logic            src_inc;
    width_e          dst_w;
    width_e          src_w;
  } xfer_cfg_t;

  localparam int CFG_W = $bits(xfer_cfg_t);
endpackage

// File: rtl/dma_cfg_align_chk.sv
module dma_cfg_align_chk
  import dma_cfg_pkg::*;
(
  input  logic [2:0] low_i,
  input  width_e     w_i,
  output logic       ok_o
);
  logic [2:0] mask;

  always_comb begin
    unique case (w_i)
      W_BYTE:  mask = 3'b000;
      W_HALF:  mask = 3'b001;
      W_WORD:  mask = 3'b011;
      default: mask = 3'b111;
    endcase
    ok_o = (w_i != W_BAD) && ((low_i & mask) == 3'b000);
  end
endmodule

// File: rtl/dma_cfg_legal.sv
module dma_cfg_legal
  import dma_cfg_pkg::*;
(
  input  width_e     src_w_i,
  input  width_e     dst_w_i,
  input  logic [2:0] blk_low_i,
  input  logic [2:0] saddr_low_i,
  input  logic [2:0] daddr_low_i,
  input  logic [2:0] dofs_low_i,
  output logic       legal_o
);
  localparam int N_CHK = 4;

  logic [2:0] chk_low [N_CHK];
  width_e     chk_w   [N_CHK];
  logic [N_CHK-1:0] chk_ok;

  // count and source address follow source width; destination pair follows destination width
  always_comb begin
    chk_low[0] = blk_low_i;   chk_w[0] = src_w_i;
    chk_low[1] = saddr_low_i; chk_w[1] = src_w_i;
    chk_low[2] = daddr_low_i; chk_w[2] = dst_w_i;
    chk_low[3] = dofs_low_i;  chk_w[3] = dst_w_i;
  end

  for (genvar g = 0; g < N_CHK; g++) begin : g_chk
    dma_cfg_align_chk u_chk (
      .low_i (chk_low[g]),
      .w_i   (chk_w[g]),
      .ok_o  (chk_ok[g])
    );
  end

  assign legal_o = &chk_ok;
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_secure_i,
  input  logic              enable_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_secure_i,
  output xfer_cfg_t         cfg_o,
  output logic [CNT_W-1:0]  blk_o,
  output logic [DATA_W-1:0] saddr_o,
  output logic [DATA_W-1:0] daddr_o,
  output logic [OFS_W-1:0]  dofs_o
);
  xfer_cfg_t wr_cfg;
  logic      sel_cfg, sec_wr_ok;

  assign wr_cfg    = xfer_cfg_t'(wr_data_i[CFG_W-1:0]);
  assign sel_cfg   = wr_en_i && (wr_addr_i == REG_CFG);
  assign sec_wr_ok = wr_secure_i && chan_secure_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      blk_o   <= '0;
      saddr_o <= '0;
      daddr_o <= '0;
      dofs_o  <= '0;
    end else begin
      if (sel_cfg) begin
        cfg_o.src_w   <= wr_cfg.src_w;
        cfg_o.dst_w   <= wr_cfg.dst_w;
        cfg_o.src_inc <= wr_cfg.src_inc;
        cfg_o.dst_inc <= wr_cfg.dst_inc;
        cfg_o.src_bl  <= wr_cfg.src_bl;
        cfg_o.dst_bl  <= wr_cfg.dst_bl;
        if (!enable_i) begin
          cfg_o.src_port <= wr_cfg.src_port;
          cfg_o.dst_port <= wr_cfg.dst_port;
        end
        if (sec_wr_ok) begin
          cfg_o.src_sec <= wr_cfg.src_sec;
          cfg_o.dst_sec <= wr_cfg.dst_sec;
        end
      end
      // channel dropped to non-secure: wipe attributes, overrides any write
      if (!chan_secure_i) begin
        cfg_o.src_sec <= 1'b0;
        cfg_o.dst_sec <= 1'b0;
      end
      if (wr_en_i && wr_addr_i == REG_BLK)   blk_o   <= wr_data_i[CNT_W-1:0];
      if (wr_en_i && wr_addr_i == REG_SADDR) saddr_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == REG_DADDR) daddr_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == REG_DOFS)  dofs_o  <= wr_data_i[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/dma_cfg_ctrl.sv
module dma_cfg_ctrl
  import dma_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [1:0]        wr_bits_i,
  input  logic              legal_i,
  output logic              enable_o,
  output logic              start_o,
  output logic              err_o
);
  logic sel, req, dis, clr;

  assign sel = wr_en_i && (wr_addr_i == REG_CTRL);
  assign req = sel && wr_bits_i[0] && !enable_o;
  assign dis = sel && !wr_bits_i[0];
  assign clr = sel && wr_bits_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= 1'b0;
      start_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      start_o <= req && legal_i;
      if (req && legal_i) enable_o <= 1'b1;
      else if (dis)       enable_o <= 1'b0;
      if (req && !legal_i) err_o <= 1'b1;
      else if (clr)        err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_secure_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_secure_i,
  input  logic [2:0]        rd_addr_i,
  input  logic              rd_secure_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              enable_o,
  output logic              start_o,
  output logic              err_o,
  output logic [1:0]        src_width_o,
  output logic [1:0]        dst_width_o,
  output logic [3:0]        src_bytes_o,
  output logic [3:0]        dst_bytes_o,
  output logic              src_inc_o,
  output logic              dst_inc_o,
  output logic [6:0]        src_beats_o,
  output logic [6:0]        dst_beats_o,
  output logic              src_port_o,
  output logic              dst_port_o,
  output logic              src_sec_o,
  output logic              dst_sec_o,
  output logic [CNT_W-1:0]  blk_bytes_o,
  output logic [DATA_W-1:0] src_addr_o,
  output logic [DATA_W-1:0] dst_addr_o,
  output logic [OFS_W-1:0]  dst_ofs_o
);
  localparam int BEAT_W = BL_W + 1;

  xfer_cfg_t cfg, cfg_rd;
  logic      legal;

  dma_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chan_secure_i (chan_secure_i),
    .enable_i      (enable_o),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .wr_secure_i   (wr_secure_i),
    .cfg_o         (cfg),
    .blk_o         (blk_bytes_o),
    .saddr_o       (src_addr_o),
    .daddr_o       (dst_addr_o),
    .dofs_o        (dst_ofs_o)
  );

  dma_cfg_legal u_legal (
    .src_w_i     (cfg.src_w),
    .dst_w_i     (cfg.dst_w),
    .blk_low_i   (blk_bytes_o[2:0]),
    .saddr_low_i (src_addr_o[2:0]),
    .daddr_low_i (dst_addr_o[2:0]),
    .dofs_low_i  (dst_ofs_o[2:0]),
    .legal_o     (legal)
  );

  dma_cfg_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bits_i (wr_data_i[1:0]),
    .legal_i   (legal),
    .enable_o  (enable_o),
    .start_o   (start_o),
    .err_o     (err_o)
  );

  // security bits hidden unless both access and channel are secure
  always_comb begin
    cfg_rd = cfg;
    if (!(rd_secure_i && chan_secure_i)) begin
      cfg_rd.src_sec = 1'b0;
      cfg_rd.dst_sec = 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_CTRL:  rd_data_o = DATA_W'({err_o, enable_o});
      REG_CFG:   rd_data_o = DATA_W'(cfg_rd);
      REG_BLK:   rd_data_o = DATA_W'(blk_bytes_o);
      REG_SADDR: rd_data_o = src_addr_o;
      REG_DADDR: rd_data_o = dst_addr_o;
      REG_DOFS:  rd_data_o = DATA_W'(dst_ofs_o);
      default:   rd_data_o = '0;
    endcase
  end

  assign src_width_o = cfg.src_w;
  assign dst_width_o = cfg.dst_w;
  assign src_bytes_o = 4'd1 << cfg.src_w;
  assign dst_bytes_o = 4'd1 << cfg.dst_w;
  assign src_inc_o   = cfg.src_inc;
  assign dst_inc_o   = cfg.dst_inc;
  assign src_beats_o = BEAT_W'(cfg.src_bl) + BEAT_W'(1);
  assign dst_beats_o = BEAT_W'(cfg.dst_bl) + BEAT_W'(1);
  assign src_port_o  = cfg.src_port;
  assign dst_port_o  = cfg.dst_port;
  assign src_sec_o   = cfg.src_sec;
  assign dst_sec_o   = cfg.dst_sec;
endmodule

// File: rtl/dma_chan_cfg_chk.sv
module dma_chan_cfg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chan_secure_i,
  input logic [2:0]        rd_addr_i,
  input logic              rd_secure_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              enable_o,
  input logic              start_o,
  input logic              err_o,
  input logic              src_port_o,
  input logic              dst_port_o,
  input logic              src_sec_o,
  input logic              dst_sec_o
);
  a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r5_start_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> enable_o);

  a_r6_err_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!start_o && !$rose(enable_o)));

  a_r7_port_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_o) |-> ($stable(src_port_o) && $stable(dst_port_o)));

  a_r9_sec_wiped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(chan_secure_i) |-> (!src_sec_o && !dst_sec_o));

  a_r10_sec_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 3'd1 && !rd_secure_i) |-> (rd_data_o[9:8] == 2'b00));
endmodule

bind dma_chan_cfg dma_chan_cfg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_chan_cfg_tb_top.sv
module dma_chan_cfg_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int OFS_W  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic chan_secure_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic wr_secure_i = 1'b0;
  logic [2:0] rd_addr_i = '0;
  logic rd_secure_i = 1'b0;
  logic [DATA_W-1:0] rd_data_o;
  logic enable_o, start_o, err_o;
  logic [1:0] src_width_o, dst_width_o;
  logic [3:0] src_bytes_o, dst_bytes_o;
  logic src_inc_o, dst_inc_o;
  logic [6:0] src_beats_o, dst_beats_o;
  logic src_port_o, dst_port_o, src_sec_o, dst_sec_o;
  logic [CNT_W-1:0] blk_bytes_o;
  logic [DATA_W-1:0] src_addr_o, dst_addr_o;
  logic [OFS_W-1:0] dst_ofs_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dma_chan_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) dut_i (.clk_i(clk), .*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic sec = 1'b0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; wr_secure_i = sec;
    @(posedge clk); #1;
    wr_en_i = 1'b0; wr_secure_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic sec, output logic [31:0] d);
    rd_addr_i = a; rd_secure_i = sec; #1; d = rd_data_o;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sw, input logic [1:0] dw,
      input logic sp, input logic dp, input logic ss, input logic ds,
      input logic [5:0] sbl, input logic [5:0] dbl);
    return {10'd0, dbl, sbl, ds, ss, dp, sp, 1'b0, 1'b1, dw, sw};
  endfunction

  task automatic set_all(input logic [31:0] cfg, input logic [31:0] blk,
      input logic [31:0] sa, input logic [31:0] da, input logic [31:0] dof);
    wr(3'd1, cfg); wr(3'd2, blk); wr(3'd3, sa); wr(3'd4, da); wr(3'd5, dof);
  endtask

  // enable request; expect accept or refuse, then return to idle
  task automatic try_en(input string tag, input bit ok);
    wr(3'd0, 32'h1);
    chk({tag, " enable"}, enable_o, ok);
    chk({tag, " start"}, start_o, ok);
    chk({tag, " err"}, err_o, !ok);
    if (ok) wr(3'd0, 32'h0);
    else begin
      wr(3'd0, 32'h2);
      chk({tag, " err cleared"}, err_o, 0);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R11 enable", enable_o, 0);
    chk("R11 err", err_o, 0);
    chk("R11 start", start_o, 0);
    rd(3'd1, 1'b1, d);
    chk("R11 cfg", d, 0);
    chk("R11 bytes", src_bytes_o, 1);
    chk("R11 beats", dst_beats_o, 1);
  endtask

  task automatic t_legal;
    set_all(mk(2'd2, 2'd1, 0, 0, 0, 0, 6'd3, 6'd0), 8, 32'h100, 32'h202, 2);
    chk("R12 src bytes", src_bytes_o, 4);
    chk("R12 dst bytes", dst_bytes_o, 2);
    chk("R12 src beats", src_beats_o, 4);
    chk("R12 dst beats", dst_beats_o, 1);
    chk("R12 src inc", src_inc_o, 1);
    wr(3'd0, 32'h1);
    chk("R5 enable", enable_o, 1);
    chk("R5 start", start_o, 1);
    chk("R5 err", err_o, 0);
    @(posedge clk); #1;
    chk("R5 start drops", start_o, 0);
    chk("R5 stays enabled", enable_o, 1);
    wr(3'd0, 32'h0);
    chk("R13 disabled", enable_o, 0);
  endtask

  task automatic t_ports;
    wr(3'd0, 32'h1);
    wr(3'd1, mk(2'd2, 2'd1, 1, 1, 0, 0, 6'd3, 6'd0));
    chk("R7 src port locked", src_port_o, 0);
    chk("R7 dst port locked", dst_port_o, 0);
    wr(3'd0, 32'h0);
    wr(3'd1, mk(2'd2, 2'd1, 1, 1, 0, 0, 6'd3, 6'd0));
    chk("R7 src port open", src_port_o, 1);
    chk("R7 dst port open", dst_port_o, 1);
  endtask

  task automatic t_width;
    wr(3'd1, mk(2'd3, 2'd1, 0, 0, 0, 0, 0, 0));
    try_en("R1 src code3", 0);
    wr(3'd1, mk(2'd0, 2'd3, 0, 0, 0, 0, 0, 0));
    try_en("R1 dst code3", 0);
    wr(3'd1, mk(2'd3, 2'd0, 0, 0, 0, 0, 0, 0));
    wr(3'd0, 32'h1);
    chk("R6 refused enable", enable_o, 0);
    wr(3'd1, mk(2'd2, 2'd1, 0, 0, 0, 0, 0, 0));
    wr(3'd0, 32'h1);
    chk("R6 later enable ok", enable_o, 1);
    chk("R6 err sticky", err_o, 1);
    wr(3'd0, 32'h3);
    chk("R6 err cleared", err_o, 0);
    chk("R6 enable kept", enable_o, 1);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_blk;
    set_all(mk(2'd2, 2'd0, 0, 0, 0, 0, 0, 0), 6, 32'h100, 32'h201, 3);
    try_en("R2 blk 6 word", 0);
    wr(3'd2, 12);
    try_en("R2 blk 12 word", 1);
    wr(3'd1, mk(2'd1, 2'd0, 0, 0, 0, 0, 0, 0));
    wr(3'd2, 7);
    try_en("R2 blk 7 half", 0);
    wr(3'd1, mk(2'd0, 2'd0, 0, 0, 0, 0, 0, 0));
    try_en("R2 blk 7 byte", 1);
  endtask

  task automatic t_saddr;
    set_all(mk(2'd1, 2'd0, 0, 0, 0, 0, 0, 0), 8, 32'h101, 32'h200, 0);
    try_en("R3 saddr odd half", 0);
    wr(3'd3, 32'h106);
    try_en("R3 saddr even half", 1);
    wr(3'd1, mk(2'd2, 2'd0, 0, 0, 0, 0, 0, 0));
    try_en("R3 saddr 6 word", 0);
  endtask

  task automatic t_dst;
    set_all(mk(2'd0, 2'd2, 0, 0, 0, 0, 0, 0), 8, 32'h100, 32'h200, 2);
    try_en("R4 dofs 2 word", 0);
    wr(3'd5, 4);
    wr(3'd4, 32'h206);
    try_en("R4 daddr 6 word", 0);
    wr(3'd4, 32'h208);
    try_en("R4 dst aligned", 1);
  endtask

  task automatic t_sec;
    logic [31:0] d;
    @(negedge clk); chan_secure_i = 1'b1;
    wr(3'd1, mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0), 1'b0);
    chk("R8 nonsecure write src", src_sec_o, 0);
    chk("R8 nonsecure write dst", dst_sec_o, 0);
    wr(3'd1, mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0), 1'b1);
    chk("R8 secure write src", src_sec_o, 1);
    chk("R8 secure write dst", dst_sec_o, 1);
    rd(3'd1, 1'b0, d);
    chk("R10 nonsecure read", d[9:8], 0);
    rd(3'd1, 1'b1, d);
    chk("R10 secure read", d[9:8], 3);
    @(negedge clk); chan_secure_i = 1'b0;
    @(posedge clk); #1;
    chk("R9 wipe src", src_sec_o, 0);
    chk("R9 wipe dst", dst_sec_o, 0);
    wr(3'd1, mk(2'd0, 2'd0, 0, 0, 1, 1, 0, 0), 1'b1);
    chk("R8 channel not secure", {src_sec_o, dst_sec_o}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_legal();
    t_ports();
    t_width();
    t_blk();
    t_saddr();
    t_dst();
    t_sec();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule